// File: doc/BRIEF.md
# Texture Lookup Coordinate Setup

This block stands between a vertex shading datapath and a texture sampler. It takes one lookup request at a time. A request carries a four-lane operand vector (x, y, z, w) in signed fixed point, a lookup opcode, a texture unit number and a target code. The block also reads the per-object and per-unit level-of-detail bias values, and a programmable lower and upper bound for the bias clamp. From these it builds the sampler's (s, t, r, q) coordinates and the final level of detail. Vertices have no screen-space derivatives, so the base level is always zero. Each opcode uses the w lane in its own way: it can be the fourth coordinate, an extra bias term inside the clamp, or an explicit level added after the clamp.

The block sends the coordinates, the level, the unit and the target to the sampler over a valid/ready channel. It then waits for the filtered RGBA sample on a second valid/ready channel. It presents the sample as the x/y/z/w result lanes on a third channel. Only one request is in flight at a time. The block takes no new request until the result has been handed on.

Top module: `tex_coord_setup`

## Requirements
- R1: While reset is asserted and right after it is released, req_ready_o is 1 and smp_valid_o, ret_ready_o and res_valid_o are 0.
- R2: The opcode encoding is 0 for plain, 1 for bias, 2 for explicit level and 3 for projective. For opcodes 0, 1 and 2 the coordinates are (x, y, z, ONE), where ONE is 1 << FRAC (0x0100 for the default Q8.8).
- R3: For the projective opcode (3) the coordinates are (x, y, z, w), copied from the operand unchanged.
- R4: For the plain (0) and projective (3) opcodes the level is obj_bias + unit_bias, clamped to [lod_min, lod_max].
- R5: For the bias opcode (1) the level is obj_bias + unit_bias + w, clamped to [lod_min, lod_max]. The sum is formed without intermediate wrap-around.
- R6: For the explicit-level opcode (2) the level is w + clamp(obj_bias + unit_bias). Only the bias sum is clamped. The final sum saturates to the signed W-bit range.
- R7: The unit number and the 3-bit target code go to the sampler unchanged. The target codes are 0 for 1D, 1 for 2D, 2 for 3D, 3 for CUBE and 4 for RECT.
- R8: The returned R, G, B and A values appear on result lanes x, y, z and w respectively.
- R9: req_ready_o goes low the cycle after a request is accepted and stays low until the result is accepted. Requests offered in that time are ignored. The operand, the biases and the clamp bounds are captured at acceptance.
- R10: smp_valid_o and res_valid_o stay high, with their payloads stable, until the matching ready is seen.
- R11: smp_valid_o rises one cycle after the request is accepted. ret_ready_o rises one cycle after the sample request is accepted. res_valid_o rises one cycle after the sample return is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 2 | Lookup opcode |
| req_x_i | input | W | Operand lane x |
| req_y_i | input | W | Operand lane y |
| req_z_i | input | W | Operand lane z |
| req_w_i | input | W | Operand lane w |
| req_unit_i | input | UW | Texture unit number |
| req_tgt_i | input | 3 | Target code |
| obj_bias_i | input | W | Per-object level bias |
| unit_bias_i | input | W | Per-unit level bias |
| lod_min_i | input | W | Lower clamp bound for the bias sum |
| lod_max_i | input | W | Upper clamp bound for the bias sum |
| smp_valid_o | output | 1 | Sample request valid |
| smp_ready_i | input | 1 | Sampler accepts the request |
| smp_s_o | output | W | Coordinate s |
| smp_t_o | output | W | Coordinate t |
| smp_r_o | output | W | Coordinate r |
| smp_q_o | output | W | Coordinate q |
| smp_lod_o | output | W | Final level of detail |
| smp_unit_o | output | UW | Unit number to the sampler |
| smp_tgt_o | output | 3 | Target code to the sampler |
| ret_valid_i | input | 1 | Returned sample valid |
| ret_ready_o | output | 1 | Block accepts the returned sample |
| ret_r_i | input | W | Returned red |
| ret_g_i | input | W | Returned green |
| ret_b_i | input | W | Returned blue |
| ret_a_i | input | W | Returned alpha |
| res_valid_o | output | 1 | Result vector valid |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_x_o | output | W | Result lane x |
| res_y_o | output | W | Result lane y |
| res_z_o | output | W | Result lane z |
| res_w_o | output | W | Result lane w |

## Verification
Each result follows its trigger by one registered stage. The sample request is visible one cycle after the request handshake. The return channel opens one cycle after the sample handshake. The result appears one cycle after the return handshake. The bench drives inputs on the falling edge. It checks each of these three outputs at the first falling edge after the handshake that should produce it. It compares payloads only at falling edges where valid and the bench's ready are both high, which means the handshake completes on the next rising edge. Ready stalls and a variable sampler delay move every transfer around in time, while the queued expectations keep their order.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_BIAS  = 2'd1,
    OP_LEVEL = 2'd2,
    OP_PROJ  = 2'd3
  } tex_op_e;

  typedef enum logic [2:0] {
    TGT_1D   = 3'd0,
    TGT_2D   = 3'd1,
    TGT_3D   = 3'd2,
    TGT_CUBE = 3'd3,
    TGT_RECT = 3'd4
  } tex_tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;

  localparam int TGT_W = 3;
endpackage

// File: rtl/tcs_coord_sel.sv
module tcs_coord_sel #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic [W-1:0] w_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] t_o,
  output logic [W-1:0] r_o,
  output logic [W-1:0] q_o
);
  import tcs_pkg::*;

  localparam logic [W-1:0] ONE = W'(1) << FRAC;

  assign s_o = x_i;
  assign t_o = y_i;
  assign r_o = z_i;
  // only the projective form forwards w as a coordinate
  assign q_o = (op_i == OP_PROJ) ? w_i : ONE;
endmodule

// File: rtl/tcs_lod_calc.sv
module tcs_lod_calc #(
  parameter int W = 16
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] w_i,
  input  logic [W-1:0] obj_bias_i,
  input  logic [W-1:0] unit_bias_i,
  input  logic [W-1:0] lod_min_i,
  input  logic [W-1:0] lod_max_i,
  output logic [W-1:0] lod_o
);
  import tcs_pkg::*;

  // two guard bits hold a three-term sum without wrap
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] SAT_HI = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0] SAT_LO = {3'b111, {(W-1){1'b0}}};

  logic signed [EW-1:0] w_e, obj_e, unit_e, min_e, max_e;
  logic signed [EW-1:0] bias_sum, bias_clamped, level_sum, level_sat;

  assign w_e    = {{2{w_i[W-1]}}, w_i};
  assign obj_e  = {{2{obj_bias_i[W-1]}}, obj_bias_i};
  assign unit_e = {{2{unit_bias_i[W-1]}}, unit_bias_i};
  assign min_e  = {{2{lod_min_i[W-1]}}, lod_min_i};
  assign max_e  = {{2{lod_max_i[W-1]}}, lod_max_i};

  always_comb begin
    bias_sum = obj_e + unit_e;
    if (op_i == OP_BIAS) bias_sum = bias_sum + w_e;

    if (bias_sum < min_e)      bias_clamped = min_e;
    else if (bias_sum > max_e) bias_clamped = max_e;
    else                       bias_clamped = bias_sum;

    // explicit level is added after the clamp
    level_sum = w_e + bias_clamped;
    if (level_sum > SAT_HI)      level_sat = SAT_HI;
    else if (level_sum < SAT_LO) level_sat = SAT_LO;
    else                         level_sat = level_sum;

    lod_o = (op_i == OP_LEVEL) ? level_sat[W-1:0] : bias_clamped[W-1:0];
  end
endmodule

// File: rtl/tcs_ctrl.sv
module tcs_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic smp_ready_i,
  input  logic ret_valid_i,
  input  logic res_ready_i,
  output logic req_ready_o,
  output logic smp_valid_o,
  output logic ret_ready_o,
  output logic res_valid_o,
  output logic load_req_o,
  output logic load_ret_o
);
  import tcs_pkg::*;

  seq_st_e st_q, st_d;

  assign req_ready_o = (st_q == ST_IDLE);
  assign smp_valid_o = (st_q == ST_SEND);
  assign ret_ready_o = (st_q == ST_WAIT);
  assign res_valid_o = (st_q == ST_DONE);
  assign load_req_o  = req_ready_o & req_valid_i;
  assign load_ret_o  = ret_ready_o & ret_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_SEND;
      ST_SEND: if (smp_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (ret_valid_i) st_d = ST_DONE;
      ST_DONE: if (res_ready_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assert_busy_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_ret_opens_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && smp_ready_i) |=> ret_ready_o);
  assert_res_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_ready_o) |=> res_valid_o);
  assert_idle_after_res_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i) |=> req_ready_o);
endmodule

// File: rtl/tex_coord_setup.sv
module tex_coord_setup #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int UW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [W-1:0]  req_x_i,
  input  logic [W-1:0]  req_y_i,
  input  logic [W-1:0]  req_z_i,
  input  logic [W-1:0]  req_w_i,
  input  logic [UW-1:0] req_unit_i,
  input  logic [2:0]    req_tgt_i,
  input  logic [W-1:0]  obj_bias_i,
  input  logic [W-1:0]  unit_bias_i,
  input  logic [W-1:0]  lod_min_i,
  input  logic [W-1:0]  lod_max_i,
  output logic          smp_valid_o,
  input  logic          smp_ready_i,
  output logic [W-1:0]  smp_s_o,
  output logic [W-1:0]  smp_t_o,
  output logic [W-1:0]  smp_r_o,
  output logic [W-1:0]  smp_q_o,
  output logic [W-1:0]  smp_lod_o,
  output logic [UW-1:0] smp_unit_o,
  output logic [2:0]    smp_tgt_o,
  input  logic          ret_valid_i,
  output logic          ret_ready_o,
  input  logic [W-1:0]  ret_r_i,
  input  logic [W-1:0]  ret_g_i,
  input  logic [W-1:0]  ret_b_i,
  input  logic [W-1:0]  ret_a_i,
  output logic          res_valid_o,
  input  logic          res_ready_i,
  output logic [W-1:0]  res_x_o,
  output logic [W-1:0]  res_y_o,
  output logic [W-1:0]  res_z_o,
  output logic [W-1:0]  res_w_o
);
  import tcs_pkg::*;

  localparam int LANES = 4;

  logic         load_req, load_ret;
  logic [W-1:0] s_c, t_c, r_c, q_c, lod_c;
  logic [W-1:0] ret_lane [LANES];
  logic [W-1:0] res_lane [LANES];

  tcs_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .smp_ready_i (smp_ready_i),
    .ret_valid_i (ret_valid_i),
    .res_ready_i (res_ready_i),
    .req_ready_o (req_ready_o),
    .smp_valid_o (smp_valid_o),
    .ret_ready_o (ret_ready_o),
    .res_valid_o (res_valid_o),
    .load_req_o  (load_req),
    .load_ret_o  (load_ret)
  );

  tcs_coord_sel #(.W(W), .FRAC(FRAC)) u_coord (
    .op_i (req_op_i),
    .x_i  (req_x_i),
    .y_i  (req_y_i),
    .z_i  (req_z_i),
    .w_i  (req_w_i),
    .s_o  (s_c),
    .t_o  (t_c),
    .r_o  (r_c),
    .q_o  (q_c)
  );

  tcs_lod_calc #(.W(W)) u_lod (
    .op_i        (req_op_i),
    .w_i         (req_w_i),
    .obj_bias_i  (obj_bias_i),
    .unit_bias_i (unit_bias_i),
    .lod_min_i   (lod_min_i),
    .lod_max_i   (lod_max_i),
    .lod_o       (lod_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_s_o    <= '0;
      smp_t_o    <= '0;
      smp_r_o    <= '0;
      smp_q_o    <= '0;
      smp_lod_o  <= '0;
      smp_unit_o <= '0;
      smp_tgt_o  <= '0;
    end else if (load_req) begin
      smp_s_o    <= s_c;
      smp_t_o    <= t_c;
      smp_r_o    <= r_c;
      smp_q_o    <= q_c;
      smp_lod_o  <= lod_c;
      smp_unit_o <= req_unit_i;
      smp_tgt_o  <= req_tgt_i;
    end
  end

  // RGBA order maps onto xyzw order
  assign ret_lane[0] = ret_r_i;
  assign ret_lane[1] = ret_g_i;
  assign ret_lane[2] = ret_b_i;
  assign ret_lane[3] = ret_a_i;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       res_lane[gi] <= '0;
      else if (load_ret) res_lane[gi] <= ret_lane[gi];
    end
  end

  assign res_x_o = res_lane[0];
  assign res_y_o = res_lane[1];
  assign res_z_o = res_lane[2];
  assign res_w_o = res_lane[3];

  assert_smp_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> smp_valid_o);
  assert_smp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_s_o) && $stable(smp_t_o)
      && $stable(smp_r_o) && $stable(smp_q_o) && $stable(smp_lod_o)));
  assert_res_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_x_o) && $stable(res_y_o)
      && $stable(res_z_o) && $stable(res_w_o)));
  assert_tgt_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (smp_tgt_o == $past(req_tgt_i)
      && smp_unit_o == $past(req_unit_i)));
  assert_lod_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i != OP_LEVEL
      && $signed(lod_min_i) <= $signed(lod_max_i))
    |=> ($signed(smp_lod_o) >= $signed($past(lod_min_i))
      && $signed(smp_lod_o) <= $signed($past(lod_max_i))));
  assert_lane_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_ready_o) |=> (res_x_o == $past(ret_r_i) && res_w_o == $past(ret_a_i)));
endmodule

// File: tb/tex_coord_setup_test.sv
module tex_coord_setup_test;
  localparam int W  = 16;
  localparam int UW = 4;
  localparam int SW = 5*W + UW + 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_op_i = '0;
  logic [W-1:0]  req_x_i = '0, req_y_i = '0, req_z_i = '0, req_w_i = '0;
  logic [UW-1:0] req_unit_i = '0;
  logic [2:0]    req_tgt_i = '0;
  logic [W-1:0]  obj_bias_i = '0, unit_bias_i = '0, lod_min_i = '0, lod_max_i = '0;
  logic          smp_valid_o;
  logic          smp_ready_i = 1'b0;
  logic [W-1:0]  smp_s_o, smp_t_o, smp_r_o, smp_q_o, smp_lod_o;
  logic [UW-1:0] smp_unit_o;
  logic [2:0]    smp_tgt_o;
  logic          ret_valid_i = 1'b0;
  logic          ret_ready_o;
  logic [W-1:0]  ret_r_i = '0, ret_g_i = '0, ret_b_i = '0, ret_a_i = '0;
  logic          res_valid_o;
  logic          res_ready_i = 1'b0;
  logic [W-1:0]  res_x_o, res_y_o, res_z_o, res_w_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [SW-1:0] exp_smp [$];
  logic [4*W-1:0] exp_res [$];

  always #10 clk = ~clk;

  tex_coord_setup #(.W(W), .FRAC(8), .UW(UW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_op_i(req_op_i),
    .req_x_i(req_x_i), .req_y_i(req_y_i), .req_z_i(req_z_i), .req_w_i(req_w_i),
    .req_unit_i(req_unit_i), .req_tgt_i(req_tgt_i),
    .obj_bias_i(obj_bias_i), .unit_bias_i(unit_bias_i),
    .lod_min_i(lod_min_i), .lod_max_i(lod_max_i),
    .smp_valid_o(smp_valid_o), .smp_ready_i(smp_ready_i),
    .smp_s_o(smp_s_o), .smp_t_o(smp_t_o), .smp_r_o(smp_r_o), .smp_q_o(smp_q_o),
    .smp_lod_o(smp_lod_o), .smp_unit_o(smp_unit_o), .smp_tgt_o(smp_tgt_o),
    .ret_valid_i(ret_valid_i), .ret_ready_o(ret_ready_o),
    .ret_r_i(ret_r_i), .ret_g_i(ret_g_i), .ret_b_i(ret_b_i), .ret_a_i(ret_a_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_x_o(res_x_o), .res_y_o(res_y_o), .res_z_o(res_z_o), .res_w_o(res_w_o)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stub sampler: colour is a fixed function of the request
  function automatic logic [4*W-1:0] stub_rgba(logic [W-1:0] s, logic [W-1:0] t,
                                               logic [W-1:0] r, logic [W-1:0] q,
                                               logic [W-1:0] lod);
    return {W'(s + 16'h0101), W'(t ^ 16'h00ff), W'(r + q), lod};
  endfunction

  function automatic int ref_lod(int op, int w, int ob, int ub, int mn, int mx);
    int sum, cl, lv;
    sum = ob + ub + ((op == 1) ? w : 0);
    cl = (sum < mn) ? mn : ((sum > mx) ? mx : sum);
    if (op != 2) return cl;
    lv = w + cl;
    if (lv > 32767) lv = 32767;
    if (lv < -32768) lv = -32768;
    return lv;
  endfunction

  // monitor, sampler stub and ready generator
  int  cyc = 0;
  int  ret_cnt = 0;
  bit  smp_pend = 0, ret_pend = 0;
  logic [4*W-1:0] stub_q;
  always @(negedge clk) begin
    cyc++;
    if (ret_pend) begin
      ret_pend = 0;
      ret_valid_i = 1'b0;
      check(res_valid_o == 1'b1, "R11 res_valid after return", 128'(res_valid_o), 128'(1));
    end
    if (smp_pend) begin
      smp_pend = 0;
      check(ret_ready_o == 1'b1, "R11 ret_ready after sample", 128'(ret_ready_o), 128'(1));
    end
    if (ret_cnt > 0) begin
      ret_cnt--;
      if (ret_cnt == 0) begin
        ret_valid_i = 1'b1;
        {ret_r_i, ret_g_i, ret_b_i, ret_a_i} = stub_q;
      end
    end
    if (ret_valid_i && ret_ready_o) ret_pend = 1;

    smp_ready_i = (cyc % 3 != 1);
    if (rst_ni && smp_valid_o && smp_ready_i) begin
      logic [SW-1:0] act;
      act = {smp_s_o, smp_t_o, smp_r_o, smp_q_o, smp_lod_o, smp_unit_o, smp_tgt_o};
      if (exp_smp.size() == 0) begin
        check(1'b0, "R9 unexpected sample request", 128'(act), 128'(0));
      end else begin
        logic [SW-1:0] e;
        e = exp_smp.pop_front();
        check(act == e, "R2-R7 sample request {s,t,r,q,lod,unit,tgt}", 128'(act), 128'(e));
      end
      stub_q = stub_rgba(smp_s_o, smp_t_o, smp_r_o, smp_q_o, smp_lod_o);
      ret_cnt = 2 + cyc % 3;
      smp_pend = 1;
    end

    res_ready_i = (cyc % 4 != 2);
    if (rst_ni && res_valid_o && res_ready_i) begin
      logic [4*W-1:0] act;
      act = {res_x_o, res_y_o, res_z_o, res_w_o};
      if (exp_res.size() == 0) begin
        check(1'b0, "R9 unexpected result", 128'(act), 128'(0));
      end else begin
        logic [4*W-1:0] e;
        e = exp_res.pop_front();
        check(act == e, "R8 result lanes xyzw", 128'(act), 128'(e));
      end
    end
  end

  task automatic send(input int op, input int x, input int y, input int z, input int w,
                      input int ob, input int ub, input int mn, input int mx,
                      input int unit, input int tgt);
    logic [W-1:0] q, lod;
    q   = (op == 3) ? W'(w) : 16'h0100;
    lod = W'(ref_lod(op, w, ob, ub, mn, mx));
    do @(negedge clk); while (!req_ready_o);
    req_op_i = 2'(op);
    req_x_i = W'(x); req_y_i = W'(y); req_z_i = W'(z); req_w_i = W'(w);
    obj_bias_i = W'(ob); unit_bias_i = W'(ub); lod_min_i = W'(mn); lod_max_i = W'(mx);
    req_unit_i = UW'(unit); req_tgt_i = 3'(tgt);
    exp_smp.push_back({W'(x), W'(y), W'(z), q, lod, UW'(unit), 3'(tgt)});
    exp_res.push_back(stub_rgba(W'(x), W'(y), W'(z), q, lod));
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(smp_valid_o == 1'b1, "R11 smp_valid after accept", 128'(smp_valid_o), 128'(1));
    check(req_ready_o == 1'b0, "R9 busy after accept", 128'(req_ready_o), 128'(0));
    // offer junk while busy; it must produce no extra sample request
    for (int i = 0; i < 2; i++) begin
      req_valid_i = 1'b1;
      req_op_i = 2'd1; req_x_i = 16'hdead; req_w_i = 16'h1234;
      obj_bias_i = 16'h0f00; lod_min_i = 16'h8000; lod_max_i = 16'h7fff;
      @(negedge clk);
      check(req_ready_o == 1'b0, "R9 still busy", 128'(req_ready_o), 128'(0));
    end
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready_o && !smp_valid_o && !ret_ready_o && !res_valid_o,
          "R1 in reset", 128'({req_ready_o, smp_valid_o, ret_ready_o, res_valid_o}), 128'(8));
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready_o && !smp_valid_o && !ret_ready_o && !res_valid_o,
          "R1 after reset", 128'({req_ready_o, smp_valid_o, ret_ready_o, res_valid_o}), 128'(8));

    // R2 R4 plain, lod in range
    send(0, 'h0100, -'h0080, 'h0300, 'h7777, 'h0080, 'h0040, -'h0200, 'h0400, 3, 1);
    // R3 R4 projective, clamp high
    send(3, 'h0010, 'h0020, 'h0030, 'h0200, 'h0300, 'h0300, -'h0200, 'h0400, 7, 3);
    // R5 bias in range
    send(1, -'h0100, 'h0000, 'h0040, 'h0100, 'h0100, 'h0100, -'h0200, 'h0400, 0, 2);
    // R5 bias clamp low
    send(1, 'h0001, 'h0002, 'h0003, -'h0100, -'h0200, -'h0100, -'h0200, 'h0400, 15, 0);
    // R5 no wrap in a large three-term sum
    send(1, 'h0005, 'h0006, 'h0007, 'h7000, 'h7000, 'h7000, -'h0200, 'h7fff, 9, 4);
    // R6 explicit: clamp applied before adding w
    send(2, 'h0100, 'h0100, 'h0100, 'h0180, 'h0300, 'h0300, -'h0200, 'h0400, 1, 1);
    // R6 explicit saturates high and low
    send(2, 'h0000, 'h0000, 'h0000, 'h7f00, 'h0300, 'h0300, -'h0200, 'h0400, 2, 2);
    send(2, 'h0000, 'h0000, 'h0000, -'h7f00, -'h0400, 'h0000, -'h0200, 'h0400, 4, 3);
    // R7 every target code
    for (int tg = 0; tg < 5; tg++)
      send(tg % 4, 'h0040 * tg, -'h0011 * tg, 'h0101, 'h0080 + tg, 'h0010, -'h0020,
           -'h0100, 'h0100, 11 + tg, tg);

    for (int i = 0; i < 40 && (exp_smp.size() != 0 || exp_res.size() != 0); i++)
      @(negedge clk);
    check(exp_smp.size() == 0 && exp_res.size() == 0, "R9 all requests completed",
          128'(exp_smp.size() + exp_res.size()), 128'(0));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule